// File: doc/BRIEF.md
# Machine-Cycle DMA and Memory Load Controller

This block moves single bytes between memory and the outside world without software taking part. It keeps no address counter of its own. The transfer address is the general register zero of the processor's register file. That register's value arrives on an input port. After every byte, the incremented value goes back out on a write port. A peripheral raises an inbound request to have a byte stored, or an outbound request to have a byte fetched. A display controller is the typical outbound client. Software can reload register zero between bursts, which makes the peripheral see the same memory line again.

Time is divided into machine cycles of eight clocks, and a phase counter marks each one. At the last phase of every machine cycle the controller decides whether the next cycle belongs to the processor or is stolen for a transfer. While a program runs, a cycle is stolen only when the sequencer reports that the current instruction has finished. When both the clear and the wait mode inputs are held high, the block is in load mode. No program runs then. Every inbound request is served at the next boundary, so memory can be filled from switches or a keypad without a boot ROM.

Top module: `dma_loader_ctrl`

## Requirements
- R1: After reset, `cyc_phase` is 0, `dma_busy` is 0, and `mem_rd`, `mem_wr`, `r0_we` and `out_strobe` are all 0.
- R2: `cyc_phase` counts 0,1,...,7 and then returns to 0, so one machine cycle is eight clocks.
- R3: `dma_busy` changes only on the clock edge that moves `cyc_phase` from 7 to 0. A transfer therefore fills one whole machine cycle.
- R4: Load mode is on while `ld_clear` and `ld_wait` are both 1. In load mode a pending `dma_in_req` is granted at every boundary whatever `instr_end` is. The granted cycle writes `dma_in_data` to address `r0_in`.
- R5: In load mode `dma_out_req` is ignored: no read strobe occurs and register zero is not changed.
- R6: Outside load mode, a request is granted only when `instr_end` is 1 at phase 7. With `instr_end` low, no transfer happens.
- R7: When both requests are pending at a grant, the inbound request is served and the outbound one waits.
- R8: At phase 7 of every transfer cycle, `r0_we` pulses with `r0_wdata` equal to `r0_in` plus one. The value wraps from 16'hFFFF to 16'h0000.
- R9: During a transfer `mem_addr` equals `r0_in`. An outbound cycle pulses `mem_rd` at phase 4. An inbound cycle pulses `mem_wr` at phase 7, and `mem_wdata` equals `dma_in_data`.
- R10: The byte read by an outbound cycle appears on `out_data`, with `out_strobe` high for one clock at phase 5 of the same cycle.
- R11: A new value written into register zero between bursts is used as the address of the next transfer, so a memory line can be sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_in_req | input | 1 | Request to store a peripheral byte in memory |
| dma_out_req | input | 1 | Request to fetch a memory byte for a peripheral |
| ld_clear | input | 1 | Clear mode input; together with `ld_wait` selects load mode |
| ld_wait | input | 1 | Wait mode input; together with `ld_clear` selects load mode |
| instr_end | input | 1 | Sequencer flag: the current machine cycle ends an instruction |
| dma_in_data | input | 8 | Byte offered by the inbound peripheral |
| r0_in | input | 16 | Current value of register zero |
| mem_rdata | input | 8 | Memory read data |
| cyc_phase | output | 3 | Clock phase within the machine cycle |
| dma_busy | output | 1 | The current machine cycle is a transfer cycle |
| mem_addr | output | 16 | Memory address during a transfer, else 0 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| r0_we | output | 1 | Write enable for register zero |
| r0_wdata | output | 16 | Incremented value for register zero |
| out_data | output | 8 | Byte delivered to the outbound peripheral |
| out_strobe | output | 1 | `out_data` is valid this clock |

## Verification
Several behaviours are checked by assertions on every clock. The phase wraps after phase 7. The transfer kind changes only at a boundary. The inbound request wins a tie. Load mode never starts an outbound cycle. A write strobe always comes with a register-zero update at the same address. A read strobe is followed one clock later by the read byte on `out_data`. Other behaviours can only be shown by the bench's scenarios, because they need memory and register-zero models. These are: the right bytes land at consecutive addresses, the address wraps at the top of memory, the same line is sent again after a reload, and requests are held off when `instr_end` stays low.

// File: rtl/dma_loader_pkg.sv
package dma_loader_pkg;
    typedef enum logic [1:0] {
        XK_CPU = 2'd0,
        XK_IN  = 2'd1,
        XK_OUT = 2'd2
    } xfer_kind_e;
endpackage

// File: rtl/dma_phase_gen.sv
module dma_phase_gen #(
    parameter int PHASES = 8,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          boundary
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == LAST) st_d.ph = '0;
        else                 st_d.ph = st_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase    = st_q.ph;
    assign boundary = (st_q.ph == LAST);

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (phase == '0));
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       in_req,
    input  logic       out_req,
    input  logic       load_mode,
    input  logic       instr_end,
    output xfer_kind_e kind
);
    typedef struct packed {
        xfer_kind_e kind;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       in_ok, out_ok;

    always_comb begin
        in_ok  = in_req && (load_mode || instr_end);
        out_ok = out_req && !load_mode && instr_end;
        st_d   = st_q;
        if (boundary) begin
            if (in_ok)       st_d.kind = XK_IN;
            else if (out_ok) st_d.kind = XK_OUT;
            else             st_d.kind = XK_CPU;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{kind: XK_CPU};
        else        st_q <= st_d;
    end

    assign kind = st_q.kind;

    // R3
    grant_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(kind));
    // R7
    in_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && in_req && out_req && instr_end) |=> (kind == XK_IN));
    // R5
    load_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && load_mode && !in_req) |=> (kind == XK_CPU));
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_loader_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PHASES = 8,
    localparam int PW = $clog2(PHASES),
    localparam int RD_PHASE = PHASES / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_kind_e    kind,
    input  logic [PW-1:0] phase,
    input  logic [AW-1:0] r0_in,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          r0_we,
    output logic [AW-1:0] r0_wdata,
    output logic [DW-1:0] out_data,
    output logic          out_strobe
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);
    localparam logic [PW-1:0] RDP  = PW'(RD_PHASE);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          stb;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       busy;

    always_comb begin
        busy      = (kind != XK_CPU);
        mem_addr  = busy ? r0_in : '0;
        mem_rd    = (kind == XK_OUT) && (phase == RDP);
        mem_wr    = (kind == XK_IN) && (phase == LAST);
        mem_wdata = (kind == XK_IN) ? in_data : '0;
        r0_we     = busy && (phase == LAST);
        r0_wdata  = r0_in + 1'b1;

        st_d      = st_q;
        st_d.stb  = mem_rd;
        if (mem_rd) st_d.data = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data   = st_q.data;
    assign out_strobe = st_q.stb;
endmodule

// File: rtl/dma_loader_ctrl.sv
module dma_loader_ctrl
    import dma_loader_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PHASES = 8,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_in_req,
    input  logic          dma_out_req,
    input  logic          ld_clear,
    input  logic          ld_wait,
    input  logic          instr_end,
    input  logic [DW-1:0] dma_in_data,
    input  logic [AW-1:0] r0_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] cyc_phase,
    output logic          dma_busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          r0_we,
    output logic [AW-1:0] r0_wdata,
    output logic [DW-1:0] out_data,
    output logic          out_strobe
);
    logic       boundary;
    logic       load_mode;
    xfer_kind_e kind;

    assign load_mode = ld_clear && ld_wait;

    dma_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(cyc_phase), .boundary(boundary)
    );

    dma_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .in_req(dma_in_req), .out_req(dma_out_req),
        .load_mode(load_mode), .instr_end(instr_end), .kind(kind)
    );

    dma_xfer #(.AW(AW), .DW(DW), .PHASES(PHASES)) u_xfer (
        .clk(clk), .rst_n(rst_n), .kind(kind), .phase(cyc_phase),
        .r0_in(r0_in), .in_data(dma_in_data), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata),
        .out_data(out_data), .out_strobe(out_strobe)
    );

    assign dma_busy = (kind != XK_CPU);

    // R9
    wr_pairs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (r0_we && mem_addr == r0_in && mem_wdata == dma_in_data));
    // R10
    rd_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (out_strobe && out_data == $past(mem_rdata)));
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R8
    r0_upd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r0_we |-> (dma_busy && boundary));
endmodule

// File: tb/tb_dma_loader_ctrl.sv
module tb_dma_loader_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_in_req = 1'b0, dma_out_req = 1'b0;
    logic        ld_clear = 1'b0, ld_wait = 1'b0, instr_end = 1'b0;
    logic [7:0]  dma_in_data, mem_rdata, mem_wdata, out_data;
    logic [15:0] r0, mem_addr, r0_wdata;
    logic [2:0]  cyc_phase;
    logic        dma_busy, mem_rd, mem_wr, r0_we, out_strobe;

    logic [7:0]  mem [0:255];
    logic [7:0]  in_vals [0:63];
    logic [7:0]  out_log [0:63];
    int          wr_cnt = 0, rd_cnt = 0, out_n = 0;
    int          total = 0, bad = 0;
    logic        r0_set = 1'b0;
    logic [15:0] r0_set_val = '0;
    logic        mon_on = 1'b0;
    logic        prev_busy = 1'b0;
    logic [2:0]  prev_phase = '0;

    always #5 clk = ~clk;

    dma_loader_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .ld_clear(ld_clear), .ld_wait(ld_wait), .instr_end(instr_end),
        .dma_in_data(dma_in_data), .r0_in(r0), .mem_rdata(mem_rdata),
        .cyc_phase(cyc_phase), .dma_busy(dma_busy), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .r0_we(r0_we), .r0_wdata(r0_wdata), .out_data(out_data), .out_strobe(out_strobe)
    );

    assign dma_in_data = in_vals[wr_cnt % 64];
    assign mem_rdata   = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (r0_set)      r0 <= r0_set_val;
        else if (r0_we)  r0 <= r0_wdata;
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock monitor: strobe phases (R9), boundary-only busy change (R3), output log (R10)
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_rd) chk(cyc_phase == 3'd4, "R9 read phase", cyc_phase, 4);
            if (mem_wr) chk(cyc_phase == 3'd7, "R9 write phase", cyc_phase, 7);
            if (dma_busy != prev_busy)
                chk(cyc_phase == 3'd0, "R3 busy changes at boundary", cyc_phase, 0);
            if (out_strobe) begin
                chk(cyc_phase == 3'd5, "R10 strobe phase", cyc_phase, 5);
                out_log[out_n % 64] = out_data;
                out_n++;
            end
            if (cyc_phase != 3'd0)
                chk(cyc_phase == prev_phase + 3'd1, "R2 phase step", cyc_phase, prev_phase + 1);
        end
        prev_busy  = dma_busy;
        prev_phase = cyc_phase;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        cycles(20);
        while (dma_busy) @(negedge clk);
    endtask

    task automatic load_r0(input logic [15:0] v);
        @(negedge clk);
        r0_set = 1'b1; r0_set_val = v;
        @(negedge clk);
        r0_set = 1'b0;
    endtask

    task automatic wait_cnt(ref int cnt, input int target);
        int guard = 0;
        while (cnt < target && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        int base_w, base_r, base_o, n;
        logic [15:0] r0_before;
        void'($urandom(32'd1802));
        for (int i = 0; i < 64; i++) in_vals[i] = 8'($urandom);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        r0 = 16'h0000;

        // R1 reset state
        #3;
        chk(cyc_phase == 0 && !dma_busy, "R1 reset phase/busy", {cyc_phase, dma_busy}, 0);
        chk(!mem_rd && !mem_wr && !r0_we && !out_strobe, "R1 reset strobes",
            {mem_rd, mem_wr, r0_we, out_strobe}, 0);
        cycles(2);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4 load mode, inbound bytes to consecutive addresses, instr_end low
        load_r0(16'h0010);
        ld_clear = 1'b1; ld_wait = 1'b1;
        base_w = wr_cnt;
        dma_in_req = 1'b1;
        wait_cnt(wr_cnt, base_w + 6);
        dma_in_req = 1'b0;
        settle();
        n = wr_cnt - base_w;
        chk(n >= 6, "R4 load writes done", n, 6);
        for (int i = 0; i < n; i++)
            chk(mem[8'h10 + i] == in_vals[(base_w + i) % 64], "R4 load byte", mem[8'h10 + i],
                in_vals[(base_w + i) % 64]);
        chk(r0 == 16'h0010 + 16'(n), "R8 r0 advanced", r0, 16'h0010 + n);

        // R5 load mode ignores outbound request
        r0_before = r0; base_r = rd_cnt;
        dma_out_req = 1'b1; instr_end = 1'b1;
        cycles(48);
        dma_out_req = 1'b0;
        settle();
        chk(rd_cnt == base_r, "R5 no read in load mode", rd_cnt - base_r, 0);
        chk(r0 == r0_before, "R5 r0 untouched", r0, r0_before);

        // R6 run mode, instr_end low holds requests off
        ld_clear = 1'b0; instr_end = 1'b0;
        base_w = wr_cnt; r0_before = r0;
        dma_in_req = 1'b1;
        cycles(48);
        chk(wr_cnt == base_w, "R6 held off", wr_cnt - base_w, 0);
        chk(r0 == r0_before, "R6 r0 held", r0, r0_before);
        instr_end = 1'b1;
        cycles(24);
        dma_in_req = 1'b0;
        settle();
        chk(wr_cnt > base_w, "R6 granted with instr_end", wr_cnt - base_w, 1);

        // R7 priority of inbound
        base_w = wr_cnt; base_r = rd_cnt;
        dma_in_req = 1'b1; dma_out_req = 1'b1;
        cycles(40);
        dma_in_req = 1'b0; dma_out_req = 1'b0;
        settle();
        chk(rd_cnt == base_r, "R7 out waits", rd_cnt - base_r, 0);
        chk(wr_cnt >= base_w + 4, "R7 in served", wr_cnt - base_w, 4);

        // R10 outbound burst from 0x40
        load_r0(16'h0040);
        base_o = out_n;
        dma_out_req = 1'b1;
        wait_cnt(out_n, base_o + 5);
        dma_out_req = 1'b0;
        settle();
        n = out_n - base_o;
        for (int i = 0; i < n; i++)
            chk(out_log[(base_o + i) % 64] == mem[8'h40 + i], "R10 out byte",
                out_log[(base_o + i) % 64], mem[8'h40 + i]);
        chk(r0 == 16'h0040 + 16'(n), "R8 r0 after out", r0, 16'h0040 + n);

        // R11 reload r0 repeats the line
        load_r0(16'h0040);
        base_o = out_n;
        dma_out_req = 1'b1;
        wait_cnt(out_n, base_o + 3);
        dma_out_req = 1'b0;
        settle();
        for (int i = 0; i < 3; i++)
            chk(out_log[(base_o + i) % 64] == mem[8'h40 + i], "R11 repeated line",
                out_log[(base_o + i) % 64], mem[8'h40 + i]);

        // R3 request raised mid-cycle is not granted before the boundary
        while (cyc_phase != 3'd2) @(negedge clk);
        dma_out_req = 1'b1;
        while (cyc_phase != 3'd6) @(negedge clk);
        chk(!dma_busy, "R3 no mid-cycle grant", dma_busy, 0);
        while (cyc_phase != 3'd0) @(negedge clk);
        chk(dma_busy, "R3 grant at boundary", dma_busy, 1);
        dma_out_req = 1'b0;
        settle();

        // R8 wrap of register zero
        load_r0(16'hFFFF);
        ld_clear = 1'b1; ld_wait = 1'b1; instr_end = 1'b0;
        base_w = wr_cnt;
        dma_in_req = 1'b1;
        wait_cnt(wr_cnt, base_w + 1);
        dma_in_req = 1'b0;
        settle();
        n = wr_cnt - base_w;
        chk(mem[8'hFF] == in_vals[base_w % 64], "R9 byte at top", mem[8'hFF], in_vals[base_w % 64]);
        chk(r0 == 16'(16'hFFFF + n), "R8 wrap", r0, 16'(16'hFFFF + n));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule